// File: doc/BRIEF.md
# Serial Flash Identification Sequencer

This block works out which serial flash is attached, at power-up or whenever software-free startup logic asks for it. On a start pulse it runs up to four identification transactions in a fixed order. It stops at the first transaction whose reply begins with a manufacturer code that this transaction is allowed to accept. The result is held on its outputs:
- a 16-bit identifier, with the manufacturer byte in bits 15:8 and the device byte in bits 7:0;
- a valid flag;
- the erase-block size and block count derived from the identifier;
- a flag saying that the part needs flag-status polling after program and erase.

The block does not shift bits itself. It drives a byte-level command port in which each byte is a full-duplex exchange. `txStart` offers `txByte`, and `txLast` tells the shifter to release chip select once that byte has been exchanged. The shifter answers with a one-cycle `txDone` together with the received byte on `rxByte`.

Top module: `flash_id_probe`

## Requirements
- R1: The transactions are issued in the order 0x90, 0x15, 0x9F, 0xAB, one per chip-select frame. The sequence stops after the first transaction that is accepted.
- R2: The 0x90 transaction sends 0x90, then three 0x00 bytes, then exchanges two more bytes. It is accepted when the first received byte is 0xBF or 0xEF, and the identifier is then {first, second} received byte.
- R3: The 0x15 transaction sends 0x15 and then exchanges two bytes. It is accepted when the first received byte is 0x1F, and the identifier is {first, second}.
- R4: The 0x9F transaction sends 0x9F and then exchanges three bytes. When the first received byte is 0x1F, the identifier is {first, second}. When the first received byte is 0x01, 0x1C, 0x20 or 0xC2, the identifier is {first, third}. Any other first byte is rejected.
- R5: The 0xAB transaction sends 0xAB, then three 0x00 bytes, then exchanges two bytes. It is accepted when the first received byte is 0x11 or 0x12, and the identifier is {first, second}. No transaction ever follows it.
- R6: When no transaction is accepted, `flashId` is 0x0000 and `idValid` is 0. In every case `probeDone` pulses for one cycle at the end, and `busy` falls in the next cycle.
- R7: `txLast` is set on the final byte of each transaction. At least GAP_CYCLES clock cycles separate the `txDone` of that final byte from the next `txStart`.
- R8: For manufacturers 0x01, 0x20, 0xC2 and 0xEF, `blockKb` is 64 and `blockCount` depends on the device byte:
  - 0x11 gives 4 blocks; each step up to 0x16 doubles the count, so 0x16 gives 128;
  - 0x17 or 0x18 gives 256;
  - 0x19 gives 512;
  - 0x20 gives 1024.

  Any other manufacturer or device byte gives 0 for both outputs.
- R9: `needFlagPoll` is 1 exactly when R8 applies and the device byte is 0x20.
- R10: `flashId`, `idValid` and the geometry outputs stay unchanged from the end of a run until the next accepted `probeStart`. A `probeStart` that arrives while `busy` is high is ignored.
- R11: After reset, `busy`, `idValid`, `txStart` and `needFlagPoll` are 0 and `flashId` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| probeStart | input | 1 | Pulse that begins an identification run |
| busy | output | 1 | High while a run is in progress |
| probeDone | output | 1 | One-cycle pulse when a run ends |
| idValid | output | 1 | An accepted identifier is held |
| flashId | output | 16 | Manufacturer byte in bits 15:8, device byte in bits 7:0 |
| blockKb | output | 8 | Erase block size in KB, 0 when the geometry is unknown |
| blockCount | output | CNT_W | Number of erase blocks, 0 when the geometry is unknown |
| needFlagPoll | output | 1 | The part needs flag-status polling |
| txStart | output | 1 | Request one byte exchange |
| txByte | output | 8 | Byte to transmit, valid with txStart |
| txLast | output | 1 | Release chip select after this byte |
| txDone | input | 1 | Byte exchange finished |
| rxByte | input | 8 | Received byte, valid with txDone |

## Verification
The in-line assertions check several properties on every cycle:
- the chip-select gap, measured by an independent counter;
- that byte requests happen only while a run is in progress;
- that `busy` drops after `probeDone`;
- that a valid identifier carries a nonzero manufacturer byte;
- that the polling flag only goes with the 64 KB family;
- that the held results stay stable while idle.

Only the bench scenarios can show the rest:
- that the opcode order and the dummy-byte counts are right;
- that each transaction accepts exactly its own manufacturer set and picks the right byte;
- that a full miss leaves a zero identifier;
- that the geometry table is correct;
- that a start during a run neither restarts nor alters the result.

// File: rtl/flash_id_probe_pkg.sv
package flash_id_probe_pkg;

  localparam int NUM_PROBES = 4;
  localparam logic [7:0] FAMILY_KB = 8'd64;

  typedef struct packed {
    logic       clearId;
    logic       capture;
    logic [2:0] capIdx;
    logic       accept;
    logic [1:0] probeSel;
  } probeStrobes_t;

  function automatic logic [7:0] probeOpcode(input logic [1:0] p);
    case (p)
      2'd0:    probeOpcode = 8'h90;
      2'd1:    probeOpcode = 8'h15;
      2'd2:    probeOpcode = 8'h9F;
      default: probeOpcode = 8'hAB;
    endcase
  endfunction

  // bytes sent before the reply bytes start (opcode plus dummies)
  function automatic logic [2:0] probeHeader(input logic [1:0] p);
    probeHeader = (p == 2'd0 || p == 2'd3) ? 3'd4 : 3'd1;
  endfunction

  function automatic logic [2:0] probeReplyLen(input logic [1:0] p);
    probeReplyLen = (p == 2'd2) ? 3'd3 : 3'd2;
  endfunction

endpackage

// File: rtl/flash_id_probe_ctrl.sv
module flash_id_probe_ctrl
  import flash_id_probe_pkg::*;
#(
  parameter int GAP_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          probeStart,
  input  logic          matchNow,
  input  logic          txDone,
  output probeStrobes_t strb,
  output logic          txStart,
  output logic [7:0]    txByte,
  output logic          txLast,
  output logic          busy,
  output logic          probeDone
);

  localparam int GW = $clog2(GAP_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_WAIT, S_CHECK, S_GAP, S_FIN} state_t;

  state_t        state;
  logic [1:0]    probe;
  logic [2:0]    idx;
  logic [GW-1:0] gapCnt;
  logic [2:0]    hdrLen;
  logic [2:0]    totalLen;
  logic          lastIdx;

  assign hdrLen   = probeHeader(probe);
  assign totalLen = hdrLen + probeReplyLen(probe);
  assign lastIdx  = (idx == totalLen - 3'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      probe  <= '0;
      idx    <= '0;
      gapCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (probeStart) begin
          state <= S_SEND;
          probe <= '0;
          idx   <= '0;
        end
        S_SEND: state <= S_WAIT;
        S_WAIT: if (txDone) begin
          if (lastIdx) state <= S_CHECK;
          else begin
            idx   <= idx + 3'd1;
            state <= S_SEND;
          end
        end
        S_CHECK: begin
          if (matchNow || probe == 2'(NUM_PROBES - 1)) state <= S_FIN;
          else begin
            gapCnt <= '0;
            state  <= S_GAP;
          end
        end
        S_GAP: begin
          if (gapCnt == GW'(GAP_CYCLES - 1)) begin
            probe <= probe + 2'd1;
            idx   <= '0;
            state <= S_SEND;
          end else gapCnt <= gapCnt + 1'b1;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.probeSel = probe;
    strb.capIdx   = idx - hdrLen;
    strb.clearId  = (state == S_IDLE) && probeStart;
    strb.capture  = (state == S_WAIT) && txDone && (idx >= hdrLen);
    strb.accept   = (state == S_CHECK) && matchNow;
  end

  assign txStart   = (state == S_SEND);
  assign txByte    = (idx == 3'd0) ? probeOpcode(probe) : 8'h00;
  assign txLast    = lastIdx;
  assign busy      = (state != S_IDLE);
  assign probeDone = (state == S_FIN);

  // independent monitor of the chip-select idle time
  logic          lastOut;
  logic [GW-1:0] sinceLast;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastOut   <= 1'b0;
      sinceLast <= GW'(GAP_CYCLES);
    end else begin
      if (txStart) lastOut <= txLast;
      else if (txDone) lastOut <= 1'b0;
      if (txDone && lastOut) sinceLast <= '0;
      else if (sinceLast < GW'(GAP_CYCLES)) sinceLast <= sinceLast + 1'b1;
    end
  end

  assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> (sinceLast >= GW'(GAP_CYCLES)));
  assert_txstart_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> busy);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    probeDone |=> !busy);

endmodule

// File: rtl/flash_id_probe_dp.sv
module flash_id_probe_dp
  import flash_id_probe_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  probeStrobes_t    strb,
  input  logic [7:0]       rxByte,
  output logic             matchNow,
  output logic [15:0]      flashId,
  output logic             idValid,
  output logic [7:0]       blockKb,
  output logic [CNT_W-1:0] blockCount,
  output logic             needFlagPoll
);

  logic [7:0]  reply0, reply1, reply2;
  logic [7:0]  mfr;
  logic [15:0] idNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reply0 <= '0;
      reply1 <= '0;
      reply2 <= '0;
    end else if (strb.capture) begin
      case (strb.capIdx)
        3'd0:    reply0 <= rxByte;
        3'd1:    reply1 <= rxByte;
        default: reply2 <= rxByte;
      endcase
    end
  end

  assign mfr = reply0;

  always_comb begin
    idNext = {mfr, reply1};
    case (strb.probeSel)
      2'd0: matchNow = (mfr == 8'hBF) || (mfr == 8'hEF);
      2'd1: matchNow = (mfr == 8'h1F);
      2'd2: begin
        matchNow = (mfr == 8'h1F) || (mfr == 8'h01) || (mfr == 8'h1C) ||
                   (mfr == 8'h20) || (mfr == 8'hC2);
        if (mfr != 8'h1F) idNext = {mfr, reply2};
      end
      default: matchNow = (mfr == 8'h11) || (mfr == 8'h12);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashId <= '0;
      idValid <= 1'b0;
    end else if (strb.clearId) begin
      flashId <= '0;
      idValid <= 1'b0;
    end else if (strb.accept) begin
      flashId <= idNext;
      idValid <= 1'b1;
    end
  end

  // geometry of the 64 KB erase-block family
  logic       family;
  logic [3:0] sizeLog;
  logic [7:0] devCode;

  assign devCode = flashId[7:0];
  assign family  = idValid && ((flashId[15:8] == 8'h01) || (flashId[15:8] == 8'h20) ||
                               (flashId[15:8] == 8'hC2) || (flashId[15:8] == 8'hEF));

  always_comb begin
    if (devCode >= 8'h11 && devCode <= 8'h16) sizeLog = 4'(devCode - 8'h0F);
    else if (devCode == 8'h17 || devCode == 8'h18) sizeLog = 4'd8;
    else if (devCode == 8'h19) sizeLog = 4'd9;
    else if (devCode == 8'h20) sizeLog = 4'd10;
    else sizeLog = 4'd0;
  end

  assign blockKb      = (family && sizeLog != 4'd0) ? FAMILY_KB : 8'd0;
  assign blockCount   = (family && sizeLog != 4'd0) ? (CNT_W'(1) << sizeLog) : '0;
  assign needFlagPoll = family && (devCode == 8'h20);

  assert_valid_mfr_R6: assert property (@(posedge clk) disable iff (!rstN)
    idValid |-> (flashId[15:8] != 8'h00));
  assert_poll_family_R9: assert property (@(posedge clk) disable iff (!rstN)
    needFlagPoll |-> (idValid && blockKb == FAMILY_KB));

endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import flash_id_probe_pkg::*;
#(
  parameter int GAP_CYCLES = 4,
  parameter int CNT_W      = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             probeStart,
  output logic             busy,
  output logic             probeDone,
  output logic             idValid,
  output logic [15:0]      flashId,
  output logic [7:0]       blockKb,
  output logic [CNT_W-1:0] blockCount,
  output logic             needFlagPoll,
  output logic             txStart,
  output logic [7:0]       txByte,
  output logic             txLast,
  input  logic             txDone,
  input  logic [7:0]       rxByte
);

  probeStrobes_t strb;
  logic          matchNow;

  flash_id_probe_ctrl #(.GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .probeStart(probeStart), .matchNow(matchNow),
    .txDone(txDone), .strb(strb), .txStart(txStart), .txByte(txByte),
    .txLast(txLast), .busy(busy), .probeDone(probeDone)
  );

  flash_id_probe_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte), .matchNow(matchNow),
    .flashId(flashId), .idValid(idValid), .blockKb(blockKb),
    .blockCount(blockCount), .needFlagPoll(needFlagPoll)
  );

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !probeStart) |=> ($stable(flashId) && $stable(idValid)));

endmodule

// File: tb/flash_id_probe_test.sv
`timescale 1ns/1ps
module flash_id_probe_test;

  localparam int GAP = 4;
  localparam int CW  = 11;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic probeStart = 1'b0;
  logic busy, probeDone, idValid, needFlagPoll, txStart, txLast;
  logic [15:0] flashId;
  logic [7:0] blockKb, txByte;
  logic [CW-1:0] blockCount;
  logic txDone = 1'b0;
  logic [7:0] rxByte = 8'h00;

  always #2 clk = ~clk;

  flash_id_probe #(.GAP_CYCLES(GAP), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .probeStart(probeStart), .busy(busy),
    .probeDone(probeDone), .idValid(idValid), .flashId(flashId),
    .blockKb(blockKb), .blockCount(blockCount), .needFlagPoll(needFlagPoll),
    .txStart(txStart), .txByte(txByte), .txLast(txLast), .txDone(txDone),
    .rxByte(rxByte)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [15:0] r90, r15, rab;
  logic [23:0] r9f;
  logic [7:0]  opLog[$];
  bit          firstOfRun;
  int          cycle = 0, lastDoneCyc = 0, latCnt = 0, pos = 0;
  bit          inTxn = 0, pend = 0, pendLast = 0;
  logic [7:0]  curOp, pendRx;

  function automatic logic [7:0] replyByte(input logic [7:0] op, input int p);
    int h;
    h = (op == 8'h90 || op == 8'hAB) ? 4 : 1;
    if (p < h) return 8'hFF;
    case (op)
      8'h90:   return (p - h == 0) ? r90[15:8] : r90[7:0];
      8'h15:   return (p - h == 0) ? r15[15:8] : r15[7:0];
      8'h9F:   return (p - h == 0) ? r9f[23:16] : (p - h == 1) ? r9f[15:8] : r9f[7:0];
      default: return (p - h == 0) ? rab[15:8] : rab[7:0];
    endcase
  endfunction

  always @(posedge clk) begin
    txDone <= 1'b0;
    cycle++;
    if (pend) begin
      latCnt--;
      if (latCnt == 0) begin
        txDone <= 1'b1;
        rxByte <= pendRx;
        pend = 0;
        if (pendLast) lastDoneCyc = cycle;
      end
    end
    if (txStart) begin
      if (!inTxn) begin
        curOp = txByte;
        pos = 0;
        opLog.push_back(txByte);
        if (!firstOfRun) check(7, 32'(cycle - lastDoneCyc >= GAP), 32'd1); // R7 gap
        firstOfRun = 0;
      end else pos++;
      pendRx   = replyByte(curOp, pos);
      pendLast = txLast;
      inTxn    = !txLast;
      pend     = 1;
      latCnt   = LAT;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    int          tag;
    logic [15:0] id;
    logic        v;
    int          kb;
    int          cnt;
    logic        poll;
    int          nProbes;
  } expItem_t;

  expItem_t expQ[$];
  logic [7:0] order[4] = '{8'h90, 8'h15, 8'h9F, 8'hAB};

  always @(negedge clk) begin
    if (rstN && probeDone) begin
      expItem_t e;
      if (expQ.size() == 0) check(6, 32'd1, 32'd0);
      else begin
        e = expQ.pop_front();
        check(e.tag, 32'(flashId), 32'(e.id));
        check(e.tag, 32'(idValid), 32'(e.v));
        check(8, 32'(blockKb), 32'(e.kb));
        check(8, 32'(blockCount), 32'(e.cnt));
        check(9, 32'(needFlagPoll), 32'(e.poll));
        check(1, 32'(opLog.size()), 32'(e.nProbes));   // R1 stop at first accept
        for (int k = 0; k < opLog.size() && k < 4; k++)
          check(1, 32'(opLog[k]), 32'(order[k]));       // R1 order, R5 last
      end
    end
  end

  function automatic bit inFamily(input logic [7:0] m);
    return m == 8'h01 || m == 8'h20 || m == 8'hC2 || m == 8'hEF;
  endfunction

  function automatic int famCount(input logic [7:0] d);
    if (d >= 8'h11 && d <= 8'h16) return 4 << (d - 8'h11);
    if (d == 8'h17 || d == 8'h18) return 256;
    if (d == 8'h19) return 512;
    if (d == 8'h20) return 1024;
    return 0;
  endfunction

  logic [15:0] lastId;
  logic        lastV;

  task automatic runCase(input int tag, input logic [15:0] a90, input logic [15:0] a15,
                         input logic [23:0] a9f, input logic [15:0] aab, input bit poke);
    expItem_t e;
    logic [7:0] m;
    r90 = a90; r15 = a15; r9f = a9f; rab = aab;
    e.tag = tag; e.v = 1'b1;
    m = a9f[23:16];
    if (a90[15:8] == 8'hBF || a90[15:8] == 8'hEF) begin e.id = a90; e.nProbes = 1; end
    else if (a15[15:8] == 8'h1F) begin e.id = a15; e.nProbes = 2; end
    else if (m == 8'h1F) begin e.id = a9f[23:8]; e.nProbes = 3; end
    else if (m == 8'h01 || m == 8'h1C || m == 8'h20 || m == 8'hC2) begin
      e.id = {m, a9f[7:0]}; e.nProbes = 3;
    end
    else if (aab[15:8] == 8'h11 || aab[15:8] == 8'h12) begin e.id = aab; e.nProbes = 4; end
    else begin e.id = 16'h0; e.v = 1'b0; e.nProbes = 4; end
    e.cnt  = (e.v && inFamily(e.id[15:8])) ? famCount(e.id[7:0]) : 0;
    e.kb   = (e.cnt != 0) ? 64 : 0;
    e.poll = e.v && inFamily(e.id[15:8]) && e.id[7:0] == 8'h20;
    opLog.delete();
    firstOfRun = 1;
    expQ.push_back(e);
    @(negedge clk) probeStart = 1'b1;
    @(negedge clk) probeStart = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      probeStart = 1'b1;                // R10 start while busy ignored
      @(negedge clk) probeStart = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    check(6, 32'(expQ.size()), 32'd0);  // R6 done pulse consumed the item
    lastId = e.id; lastV = e.v;
    // R10 hold: change replies, result must not move
    r90 = 16'hEF17; r15 = 16'h1F60; r9f = 24'h202020; rab = 16'h1111;
    repeat (20) @(negedge clk);
    check(10, 32'(flashId), 32'(lastId));
    check(10, 32'(idValid), 32'(lastV));
  endtask

  initial begin
    r90 = 16'hFFFF; r15 = 16'hFFFF; r9f = 24'hFFFFFF; rab = 16'hFFFF;
    firstOfRun = 1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(11, 32'(busy), 32'd0);
    check(11, 32'(idValid), 32'd0);
    check(11, 32'(flashId), 32'd0);
    check(11, 32'(txStart), 32'd0);
    check(11, 32'(needFlagPoll), 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    runCase(2, 16'hBF41, 16'hFFFF, 24'hFFFFFF, 16'hFFFF, 0);   // R2 first-probe hit
    runCase(2, 16'hEF16, 16'hFFFF, 24'hFFFFFF, 16'hFFFF, 0);   // R2 + R8 128 blocks
    runCase(3, 16'h0000, 16'h1F60, 24'hFFFFFF, 16'hFFFF, 0);   // R3
    runCase(4, 16'h0000, 16'h0000, 24'h20BA20, 16'hFFFF, 0);   // R4 third byte, R9 poll
    runCase(4, 16'h1F00, 16'h0000, 24'h010219, 16'hFFFF, 0);   // R4 512 blocks
    runCase(4, 16'h0000, 16'h1E00, 24'h1F4499, 16'hFFFF, 0);   // R4 1F keeps second
    runCase(4, 16'h0000, 16'h0000, 24'hC20018, 16'hFFFF, 1);   // R4 + R10 busy poke
    runCase(4, 16'h0000, 16'h0000, 24'h1C3011, 16'hFFFF, 0);   // R4 non-family
    runCase(5, 16'h0000, 16'h0000, 24'h000000, 16'h1111, 0);   // R5 last probe
    runCase(5, 16'h0000, 16'h0000, 24'h000000, 16'h1214, 0);   // R5
    runCase(6, 16'hBE00, 16'h1E00, 24'h020000, 16'h1300, 0);   // R6 no match
    runCase(8, 16'hEF11, 16'hFFFF, 24'hFFFFFF, 16'hFFFF, 0);   // R8 4 blocks
    runCase(8, 16'hEF14, 16'hFFFF, 24'hFFFFFF, 16'hFFFF, 0);   // R8 32 blocks
    runCase(8, 16'hEF17, 16'hFFFF, 24'hFFFFFF, 16'hFFFF, 0);   // R8 256 blocks
    runCase(8, 16'hEF30, 16'hFFFF, 24'hFFFFFF, 16'hFFFF, 0);   // R8 unknown code
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule